// File: doc/BRIEF.md
# Flag Threshold Register Port

This block holds the two 16-bit thresholds used by a FIFO's almost-empty and almost-full flag logic. It programs them and reads them back through the FIFO's own data buses, so the FIFO needs no separate configuration bus. While `cfg_mode` is high, the FIFO data ports are borrowed for configuration.

In configuration mode, each accepted write-clock edge stores `cfg_wdata` into one threshold. Each accepted read-clock edge loads one threshold into `rd_word`. Each side steps through the pair with its own one-bit selector: the empty threshold first, then the full threshold, then back to the empty threshold. The write side and the read side step independently, each in its own clock domain.

When `cfg_mode` is low, the write and read requests pass through as FIFO pointer-advance strobes, and the thresholds and readback word stay unchanged. The current threshold values are always available to the flag comparators.

Top module: `ofs_port`

## Requirements
- R1: While `rst_n` is low, both `empty_ofs` and `full_ofs` are 127 (parameter `DEFAULT_OFS`), `rd_word` is 0, and both selectors point at the empty threshold.
- R2: With `cfg_mode`=1 and `wr_req`=1, successive write-clock edges store `cfg_wdata` into `empty_ofs`, then `full_ofs`, then `empty_ofs` again, alternating. The other register is left unchanged.
- R3: With `cfg_mode`=1 and `wr_req`=0, a write-clock edge changes neither threshold nor the write-side sequence position.
- R4: With `cfg_mode`=0, `fifo_wr_go` equals `wr_req` and the thresholds do not change. With `cfg_mode`=1, `fifo_wr_go` is 0.
- R5: With `cfg_mode`=1 and `rd_req`=1, successive read-clock edges load `rd_word` with the empty threshold, then the full threshold, alternating. Bits [17:16] of `rd_word` are 0.
- R6: The read-side sequence position does not depend on the write-side position. After reset, the first readback returns the empty threshold even if an odd number of writes has occurred.
- R7: Leaving configuration mode and entering it again continues each sequence from where it stopped; the sequence is not restarted.
- R8: With `cfg_mode`=0, or with `rd_req`=0, a read-clock edge leaves `rd_word` and the read-side position unchanged. `fifo_rd_go` equals `rd_req` when `cfg_mode`=0 and is 0 when `cfg_mode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| cfg_mode | input | 1 | High: the data ports access the thresholds |
| wr_req | input | 1 | Write request (active high) |
| cfg_wdata | input | 16 | Low 16 bits of the FIFO write data bus |
| rd_req | input | 1 | Read request (active high) |
| fifo_wr_go | output | 1 | Write-pointer advance strobe to the FIFO |
| fifo_rd_go | output | 1 | Read-pointer advance strobe to the FIFO |
| rd_word | output | 18 | Readback word, zero-padded threshold |
| empty_ofs | output | 16 | Almost-empty threshold to the flag logic |
| full_ofs | output | 16 | Almost-full threshold to the flag logic |

## Verification
The hardest case to reach is a divergence between the two selectors. The bench must leave the write side on the full threshold while the read side is still on the empty one, and then leave and re-enter configuration mode. The directed sequence does this with an odd number of writes, a readback, and then a mode exit and re-entry. Random write and read operations, each with random mode and request bits, then drive the selectors through many different relative phases.

// File: rtl/ofs_port_pkg.sv
package ofs_port_pkg;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;

  function automatic ofs_sel_e sel_advance(ofs_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/ofs_wr_side.sv
module ofs_wr_side
  import ofs_port_pkg::*;
#(
  parameter int OFS_W       = 16,
  parameter int DEFAULT_OFS = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic             wr_req,
  input  logic [OFS_W-1:0] cfg_wdata,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output ofs_sel_e         sel,
  output logic             prog_stb
);
  localparam int NREG = 2;
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(DEFAULT_OFS);

  logic [OFS_W-1:0] ofs_q [NREG];
  logic [NREG-1:0]  hit;

  assign prog_stb = cfg_mode & wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel <= SEL_EMPTY;
    else if (prog_stb) sel <= sel_advance(sel);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g] = prog_stb && (int'(sel) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ofs_q[g] <= RST_VAL;
      else if (hit[g]) ofs_q[g] <= cfg_wdata;
    end
  end

  assign empty_ofs = ofs_q[int'(SEL_EMPTY)];
  assign full_ofs  = ofs_q[int'(SEL_FULL)];
endmodule

// File: rtl/ofs_rd_side.sv
module ofs_rd_side
  import ofs_port_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              rd_req,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] rd_word,
  output ofs_sel_e          sel,
  output logic              rb_stb
);
  localparam int PAD_W = DATA_W - OFS_W;

  logic [OFS_W-1:0] pick;

  assign rb_stb = cfg_mode & rd_req;
  assign pick   = (sel == SEL_FULL) ? full_ofs : empty_ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= SEL_EMPTY;
      rd_word <= '0;
    end else if (rb_stb) begin
      sel     <= sel_advance(sel);
      rd_word <= {{PAD_W{1'b0}}, pick};
    end
  end
endmodule

// File: rtl/ofs_port.sv
module ofs_port
  import ofs_port_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int OFS_W       = 16,
  parameter int DEFAULT_OFS = 127
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              wr_req,
  input  logic [OFS_W-1:0]  cfg_wdata,
  input  logic              rd_req,
  output logic              fifo_wr_go,
  output logic              fifo_rd_go,
  output logic [DATA_W-1:0] rd_word,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs
);
  ofs_sel_e wr_sel, rd_sel;
  logic     prog_stb, rb_stb;

  ofs_wr_side #(.OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_req(wr_req),
    .cfg_wdata(cfg_wdata), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .sel(wr_sel), .prog_stb(prog_stb)
  );

  ofs_rd_side #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .rd_req(rd_req),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_word(rd_word),
    .sel(rd_sel), .rb_stb(rb_stb)
  );

  assign fifo_wr_go = wr_req & ~cfg_mode;
  assign fifo_rd_go = rd_req & ~cfg_mode;
endmodule

// File: rtl/ofs_port_chk.sv
module ofs_port_chk
  import ofs_port_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int OFS_W       = 16,
  parameter int DEFAULT_OFS = 127
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              cfg_mode,
  input logic              wr_req,
  input logic [OFS_W-1:0]  cfg_wdata,
  input logic              rd_req,
  input logic              fifo_wr_go,
  input logic              fifo_rd_go,
  input logic [DATA_W-1:0] rd_word,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs,
  input ofs_sel_e          wr_sel,
  input ofs_sel_e          rd_sel,
  input logic              prog_stb
);
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(DEFAULT_OFS);

  assert_reset_ofs_R1: assert property (@(posedge wr_clk)
    $rose(rst_n) |-> (empty_ofs == RST_VAL && full_ofs == RST_VAL && wr_sel == SEL_EMPTY));

  assert_reset_rd_R1: assert property (@(posedge rd_clk)
    $rose(rst_n) |-> (rd_word == '0 && rd_sel == SEL_EMPTY));

  assert_prog_empty_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (prog_stb && wr_sel == SEL_EMPTY) |=> (empty_ofs == $past(cfg_wdata) && $stable(full_ofs)));

  assert_prog_full_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (prog_stb && wr_sel == SEL_FULL) |=> (full_ofs == $past(cfg_wdata) && $stable(empty_ofs)));

  assert_wr_toggle_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    prog_stb |=> (wr_sel != $past(wr_sel)));

  assert_wr_hold_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !(cfg_mode && wr_req) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wr_sel)));

  assert_wr_gate_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    fifo_wr_go |-> (wr_req && !cfg_mode));

  assert_pad_zero_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_word[DATA_W-1:OFS_W] == '0);

  assert_rb_empty_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (cfg_mode && rd_req && rd_sel == SEL_EMPTY) |=> rd_word[OFS_W-1:0] == $past(empty_ofs));

  assert_rd_hold_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(cfg_mode && rd_req) |=> ($stable(rd_word) && $stable(rd_sel)));

  assert_rd_gate_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    cfg_mode |-> !fifo_rd_go);
endmodule

bind ofs_port ofs_port_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
  .wr_req(wr_req), .cfg_wdata(cfg_wdata), .rd_req(rd_req),
  .fifo_wr_go(fifo_wr_go), .fifo_rd_go(fifo_rd_go), .rd_word(rd_word),
  .empty_ofs(empty_ofs), .full_ofs(full_ofs), .wr_sel(wr_sel),
  .rd_sel(rd_sel), .prog_stb(prog_stb)
);

// File: tb/test_ofs_port.sv
module test_ofs_port;
  logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic        cfg_mode = 1'b0, wr_req = 1'b0, rd_req = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        fifo_wr_go, fifo_rd_go;
  logic [17:0] rd_word;
  logic [15:0] empty_ofs, full_ofs;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_e, m_f;
  logic [17:0] m_rw;
  logic        m_wsel, m_rsel;

  ofs_port i_ofs_port (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .wr_req(wr_req), .cfg_wdata(cfg_wdata), .rd_req(rd_req),
    .fifo_wr_go(fifo_wr_go), .fifo_rd_go(fifo_rd_go), .rd_word(rd_word),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  always #5 wr_clk = ~wr_clk;
  initial begin #3; forever #5 rd_clk = ~rd_clk; end

  function automatic logic [17:0] exp_word(logic sel, logic [15:0] e, logic [15:0] f);
    return {2'b00, (sel ? f : e)};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, "empty_ofs", 32'(empty_ofs), 32'(m_e));
    chk(req, "full_ofs", 32'(full_ofs), 32'(m_f));
    chk(req, "rd_word", 32'(rd_word), 32'(m_rw));
  endtask

  task automatic do_wr(logic cfg, logic req, logic [15:0] d);
    string tag;
    tag = (cfg && req) ? "R2" : (cfg ? "R3" : "R4");
    @(negedge wr_clk);
    cfg_mode = cfg; wr_req = req; rd_req = 1'b0; cfg_wdata = d;
    #1 chk("R4", "fifo_wr_go", 32'(fifo_wr_go), 32'(req && !cfg));
    @(posedge wr_clk);
    if (cfg && req) begin
      if (!m_wsel) m_e = d; else m_f = d;
      m_wsel = !m_wsel;
    end
    #1 check_state(tag);
    wr_req = 1'b0;
  endtask

  task automatic do_rd(logic cfg, logic req);
    string tag;
    tag = (cfg && req) ? "R5" : "R8";
    @(negedge rd_clk);
    cfg_mode = cfg; rd_req = req; wr_req = 1'b0;
    #1 chk("R8", "fifo_rd_go", 32'(fifo_rd_go), 32'(req && !cfg));
    @(posedge rd_clk);
    if (cfg && req) begin
      m_rw = exp_word(m_rsel, m_e, m_f);
      m_rsel = !m_rsel;
    end
    #1 check_state(tag);
    rd_req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_e = 16'd127; m_f = 16'd127; m_rw = '0; m_wsel = 1'b0; m_rsel = 1'b0;
    repeat (4) @(posedge wr_clk);
    #2;
    check_state("R1");
    rst_n = 1'b1;
    #20;
    check_state("R1");
    // R2 sequence: empty, full, empty
    do_wr(1'b1, 1'b1, 16'h1111);
    do_wr(1'b1, 1'b1, 16'h2222);
    do_wr(1'b1, 1'b1, 16'h3333);
    chk("R2", "third write lands in empty", 32'(empty_ofs), 32'h3333);
    // R3 idle in config mode, R4 normal writes
    do_wr(1'b1, 1'b0, 16'hdead);
    do_wr(1'b0, 1'b1, 16'hbeef);
    // R6: write side sits on full; first readback still returns empty threshold
    do_rd(1'b1, 1'b1);
    chk("R6", "first readback", 32'(rd_word), 32'h3333);
    do_rd(1'b1, 1'b1);
    chk("R5", "second readback", 32'(rd_word), 32'h2222);
    do_rd(1'b0, 1'b1);
    do_rd(1'b1, 1'b0);
    // R7: leave and re-enter, write continues on full register
    do_wr(1'b0, 1'b1, 16'h0bad);
    do_wr(1'b1, 1'b1, 16'hffff);
    chk("R7", "resumed write hits full", 32'(full_ofs), 32'hffff);
    do_rd(1'b1, 1'b1);
    chk("R7", "resumed read hits empty", 32'(rd_word), 32'h3333);
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      if (r[0]) do_wr(r[1] | r[3], r[2], 16'($urandom));
      else      do_rd(r[1] | r[3], r[2]);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule